// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block turns fault conditions in a stack-machine core into a fixed entry sequence. Request lines from the stack, arithmetic and decode logic come in as a bit vector indexed by fault code. The block also checks two bus addresses itself. A data access into the special-register window is checked against a table of defined registers. A jump or call target is checked against the whole special-register window. When a fault is seen while the block is idle, it records the instruction pointer and the winning code. It then drives the data stack through four cycles. In the first it clears the stack. Next it pushes the saved IP, then it pushes the code, so the code ends up on top. In the last cycle it loads the IP from entry 0 of the software vector table.

The special-register table is built from regions. Addresses below `SFR_RW_END` can be read and written. Addresses up to `SFR_RO_END` are read-only and addresses up to `SFR_WO_END` are write-only. The rest of the window, up to `SFR_TOP`, is undefined. The block tells the bus when to drop a write to a read-only register and when to return zero for a read of a write-only register.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset `busy`, `dstk_clear`, `dstk_push`, `vec_rd_en` and `ip_load` are all 0.
- R2: When several faults are requested in the same cycle, the lowest code wins.
- R3: The edge that accepts a fault starts the sequence. The next four cycles are one clear cycle, then a push of the saved IP, then a push of the code (zero-extended), then one cycle with `ip_load` high. In that cycle `ip_load_val` equals `vec_rd_data` and `vec_rd_addr` equals `VEC0_ADDR`.
- R4: `busy` is high for exactly those four cycles and is low on the cycle after the load.
- R5: A request seen while `busy` is high is ignored. It changes neither the pushed IP nor the pushed code, and it starts no second entry.
- R6: A valid data access whose address is in [`SFR_WO_END`, `SFR_TOP`] raises code 0.
- R7: A valid jump target at or below `SFR_TOP` raises code 6. A target above `SFR_TOP` raises nothing.
- R8: `sfr_wr_block` is 1 for a valid write in [`SFR_RW_END`, `SFR_RO_END`). `sfr_rd_zero` is 1 for a valid read in [`SFR_RO_END`, `SFR_WO_END`). Neither case raises a fault.
- R9: An access to a defined register, or to any address above `SFR_TOP`, raises no fault.
- R10: Bit i of `ext_req` raises code i. The codes are: 0 illegal register access, 1 divide by zero, 2 data stack overflow, 3 data stack underflow, 4 address stack overflow, 5 address stack underflow, 6 illegal call, 7 illegal opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | NUM_CODES | Fault requests, bit index = code |
| cur_ip | input | AW | Current instruction pointer |
| mem_valid | input | 1 | Data access valid |
| mem_write | input | 1 | Data access is a write |
| mem_addr | input | AW | Data access address |
| jmp_valid | input | 1 | Jump or call target valid |
| jmp_target | input | AW | Jump or call target |
| vec_rd_data | input | AW | Vector table read data (combinational) |
| busy | output | 1 | Entry in progress, stalls fetch |
| dstk_clear | output | 1 | Clear the data stack |
| dstk_push | output | 1 | Push onto the data stack |
| dstk_push_data | output | DW | Value pushed |
| vec_rd_en | output | 1 | Vector table read enable |
| vec_rd_addr | output | AW | Vector table read address |
| ip_load | output | 1 | Load instruction pointer |
| ip_load_val | output | AW | New instruction pointer |
| sfr_wr_block | output | 1 | Drop this write (read-only register) |
| sfr_rd_zero | output | 1 | Return zero for this read (write-only register) |

## Verification
The block's own address checks can raise a fault in the same cycle as an external request. An undefined register access (code 0) or a low jump target (code 6) can coincide with any `ext_req` bit. The bench raises both in one cycle, in random mixes and in directed cases. It compares the code pushed in the third cycle with the lowest set bit of the combined request. It also fires requests in every busy cycle and checks that the pushed IP and code still belong to the first fault.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int unsigned EXC_CW = 3;

   typedef enum logic [EXC_CW-1:0] {
      EXC_SFR_ILLEGAL  = 3'd0,
      EXC_DIV_ZERO     = 3'd1,
      EXC_DSTK_OVF     = 3'd2,
      EXC_DSTK_UNF     = 3'd3,
      EXC_ASTK_OVF     = 3'd4,
      EXC_ASTK_UNF     = 3'd5,
      EXC_CALL_ILLEGAL = 3'd6,
      EXC_OPC_ILLEGAL  = 3'd7
   } exc_code_e;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_CLEAR     = 3'd1,
      ST_PUSH_IP   = 3'd2,
      ST_PUSH_CODE = 3'd3,
      ST_LOAD      = 3'd4
   } seq_state_e;
endpackage

// File: rtl/exc_addr_check.sv
module exc_addr_check #(
   parameter int unsigned AW         = 16,
   parameter int unsigned SFR_TOP    = 'h1FF,
   parameter int unsigned SFR_RW_END = 'h20,
   parameter int unsigned SFR_RO_END = 'h28,
   parameter int unsigned SFR_WO_END = 'h30
) (
   input  logic          mem_valid,
   input  logic          mem_write,
   input  logic [AW-1:0] mem_addr,
   input  logic          jmp_valid,
   input  logic [AW-1:0] jmp_target,
   output logic          illegal_sfr,
   output logic          illegal_call,
   output logic          wr_block,
   output logic          rd_zero
);
   localparam logic [AW-1:0] TOP_A = AW'(SFR_TOP);
   localparam logic [AW-1:0] RW_A  = AW'(SFR_RW_END);
   localparam logic [AW-1:0] RO_A  = AW'(SFR_RO_END);
   localparam logic [AW-1:0] WO_A  = AW'(SFR_WO_END);

   logic in_window, in_ro, in_wo, in_undef;

   always_comb begin
      in_window = (mem_addr <= TOP_A);
      in_ro     = (mem_addr >= RW_A) && (mem_addr < RO_A);
      in_wo     = (mem_addr >= RO_A) && (mem_addr < WO_A);
      in_undef  = in_window && (mem_addr >= WO_A);
   end

   assign illegal_sfr  = mem_valid && in_undef;
   assign wr_block     = mem_valid && mem_write && in_ro;
   assign rd_zero      = mem_valid && !mem_write && in_wo;
   assign illegal_call = jmp_valid && (jmp_target <= TOP_A);
endmodule

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
   parameter int unsigned N  = 8,
   parameter int unsigned CW = 3
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [CW-1:0] code
);
   logic [N:0]   lower;
   logic [N-1:0] grant;

   assign lower[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]   = req[i] && !lower[i];
      assign lower[i+1] = lower[i] || req[i];
   end

   assign any = lower[N];

   always_comb begin
      code = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) code = code | CW'(i);
      end
   end
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
   import exc_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned DW        = 16,
   parameter int unsigned CW        = 3,
   parameter int unsigned VEC0_ADDR = 'h100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_any,
   input  logic [CW-1:0] req_code,
   input  logic [AW-1:0] cur_ip,
   input  logic [AW-1:0] vec_rd_data,
   output logic          busy,
   output logic          dstk_clear,
   output logic          dstk_push,
   output logic [DW-1:0] dstk_push_data,
   output logic          vec_rd_en,
   output logic [AW-1:0] vec_rd_addr,
   output logic          ip_load,
   output logic [AW-1:0] ip_load_val
);
   seq_state_e    state_q, state_d;
   logic [AW-1:0] ip_q;
   logic [CW-1:0] code_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:      if (req_any) state_d = ST_CLEAR;
         ST_CLEAR:     state_d = ST_PUSH_IP;
         ST_PUSH_IP:   state_d = ST_PUSH_CODE;
         ST_PUSH_CODE: state_d = ST_LOAD;
         ST_LOAD:      state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ip_q    <= '0;
         code_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_any) begin
            ip_q   <= cur_ip;
            code_q <= req_code;
         end
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign dstk_clear  = (state_q == ST_CLEAR);
   assign dstk_push   = (state_q == ST_PUSH_IP) || (state_q == ST_PUSH_CODE);
   assign vec_rd_en   = (state_q == ST_LOAD);
   assign ip_load     = (state_q == ST_LOAD);
   assign vec_rd_addr = AW'(VEC0_ADDR);
   assign ip_load_val = vec_rd_data;

   always_comb begin
      dstk_push_data = '0;
      if (state_q == ST_PUSH_IP)   dstk_push_data = DW'(ip_q);
      if (state_q == ST_PUSH_CODE) dstk_push_data = DW'(code_q);
   end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_pkg::*;
#(
   parameter int unsigned AW         = 16,
   parameter int unsigned DW         = 16,
   parameter int unsigned NUM_CODES  = 8,
   parameter int unsigned SFR_TOP    = 'h1FF,
   parameter int unsigned SFR_RW_END = 'h20,
   parameter int unsigned SFR_RO_END = 'h28,
   parameter int unsigned SFR_WO_END = 'h30,
   parameter int unsigned VEC0_ADDR  = 'h100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CODES-1:0] ext_req,
   input  logic [AW-1:0]        cur_ip,
   input  logic                 mem_valid,
   input  logic                 mem_write,
   input  logic [AW-1:0]        mem_addr,
   input  logic                 jmp_valid,
   input  logic [AW-1:0]        jmp_target,
   input  logic [AW-1:0]        vec_rd_data,
   output logic                 busy,
   output logic                 dstk_clear,
   output logic                 dstk_push,
   output logic [DW-1:0]        dstk_push_data,
   output logic                 vec_rd_en,
   output logic [AW-1:0]        vec_rd_addr,
   output logic                 ip_load,
   output logic [AW-1:0]        ip_load_val,
   output logic                 sfr_wr_block,
   output logic                 sfr_rd_zero
);
   localparam int unsigned CW = EXC_CW;

   if (DW < AW) begin : g_bad_dw
      $error("exc_entry_seq: DW must hold a full IP");
   end
   if (NUM_CODES != (1 << CW)) begin : g_bad_codes
      $error("exc_entry_seq: NUM_CODES must match the code width");
   end
   if (!(SFR_RW_END <= SFR_RO_END && SFR_RO_END <= SFR_WO_END
         && SFR_WO_END <= SFR_TOP + 1)) begin : g_bad_map
      $error("exc_entry_seq: register regions out of order");
   end
   if (SFR_TOP >= (64'd1 << AW)) begin : g_bad_top
      $error("exc_entry_seq: SFR_TOP exceeds address width");
   end

   logic                 illegal_sfr, illegal_call;
   logic [NUM_CODES-1:0] all_req;
   logic                 req_any;
   logic [CW-1:0]        req_code;

   exc_addr_check #(
      .AW(AW), .SFR_TOP(SFR_TOP), .SFR_RW_END(SFR_RW_END),
      .SFR_RO_END(SFR_RO_END), .SFR_WO_END(SFR_WO_END)
   ) u_addr (
      .mem_valid   (mem_valid),
      .mem_write   (mem_write),
      .mem_addr    (mem_addr),
      .jmp_valid   (jmp_valid),
      .jmp_target  (jmp_target),
      .illegal_sfr (illegal_sfr),
      .illegal_call(illegal_call),
      .wr_block    (sfr_wr_block),
      .rd_zero     (sfr_rd_zero)
   );

   always_comb begin
      all_req = ext_req;
      all_req[EXC_SFR_ILLEGAL]  = ext_req[EXC_SFR_ILLEGAL]  | illegal_sfr;
      all_req[EXC_CALL_ILLEGAL] = ext_req[EXC_CALL_ILLEGAL] | illegal_call;
   end

   exc_prio_enc #(.N(NUM_CODES), .CW(CW)) u_prio (
      .req (all_req),
      .any (req_any),
      .code(req_code)
   );

   exc_seq_fsm #(.AW(AW), .DW(DW), .CW(CW), .VEC0_ADDR(VEC0_ADDR)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_any       (req_any),
      .req_code      (req_code),
      .cur_ip        (cur_ip),
      .vec_rd_data   (vec_rd_data),
      .busy          (busy),
      .dstk_clear    (dstk_clear),
      .dstk_push     (dstk_push),
      .dstk_push_data(dstk_push_data),
      .vec_rd_en     (vec_rd_en),
      .vec_rd_addr   (vec_rd_addr),
      .ip_load       (ip_load),
      .ip_load_val   (ip_load_val)
   );
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
   parameter int unsigned AW        = 16,
   parameter int unsigned VEC0_ADDR = 'h100
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          dstk_clear,
   input logic          dstk_push,
   input logic          vec_rd_en,
   input logic [AW-1:0] vec_rd_addr,
   input logic          ip_load,
   input logic          sfr_wr_block,
   input logic          sfr_rd_zero
);
   logic [2:0] bcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) bcnt <= '0;
      else        bcnt <= busy ? bcnt + 3'd1 : 3'd0;
   end

   // R3
   clear_then_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dstk_clear |=> dstk_push && !dstk_clear);
   // R3
   vec_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ip_load |-> vec_rd_en && vec_rd_addr == AW'(VEC0_ADDR));
   // R4
   load_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ip_load |=> !busy);
   // R4
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> bcnt < 3'd4);
   // R4
   push_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dstk_push |-> busy);
   // R5
   start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dstk_clear) |-> !$past(busy));
   // R8
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sfr_wr_block && sfr_rd_zero));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.AW(AW), .VEC0_ADDR(VEC0_ADDR)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .dstk_clear  (dstk_clear),
   .dstk_push   (dstk_push),
   .vec_rd_en   (vec_rd_en),
   .vec_rd_addr (vec_rd_addr),
   .ip_load     (ip_load),
   .sfr_wr_block(sfr_wr_block),
   .sfr_rd_zero (sfr_rd_zero)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16, DW = 16, NC = 8;
   localparam int TOP = 'h1FF, RWE = 'h20, ROE = 'h28, WOE = 'h30, VEC0 = 'h100;

   logic          clk = 0, rst_n = 0;
   logic [NC-1:0] ext_req = '0;
   logic [AW-1:0] cur_ip = '0, mem_addr = '0, jmp_target = '0, vec_rd_data = '0;
   logic          mem_valid = 0, mem_write = 0, jmp_valid = 0;
   logic          busy, dstk_clear, dstk_push, vec_rd_en, ip_load, sfr_wr_block, sfr_rd_zero;
   logic [DW-1:0] dstk_push_data;
   logic [AW-1:0] vec_rd_addr, ip_load_val;

   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_entry_seq u_dut (.*);

   task automatic chk(input string req, input logic ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] lowest(input logic [NC-1:0] r);
      for (int i = NC-1; i >= 0; i--) if (r[i]) lowest = 3'(i);
   endfunction
   function automatic logic [NC-1:0] comb_req(input logic [NC-1:0] r, input logic mv,
         input logic [AW-1:0] ma, input logic jv, input logic [AW-1:0] jt);
      comb_req = r;
      if (mv && ma >= AW'(WOE) && ma <= AW'(TOP)) comb_req[0] = 1'b1;
      if (jv && jt <= AW'(TOP)) comb_req[6] = 1'b1;
   endfunction

   task automatic idle_inputs();
      ext_req = '0; mem_valid = 0; mem_write = 0; jmp_valid = 0;
   endtask

   // Applies stimulus at a negedge; runs and checks one full entry.
   task automatic entry(input string tag, input logic [NC-1:0] r, input logic mv, input logic mw,
         input logic [AW-1:0] ma, input logic jv, input logic [AW-1:0] jt,
         input logic [AW-1:0] ip, input logic [AW-1:0] vec, input logic hold);
      logic [NC-1:0] all;
      logic [2:0] exp;
      all = comb_req(r, mv, ma, jv, jt);
      exp = lowest(all);
      ext_req = r; mem_valid = mv; mem_write = mw; mem_addr = ma;
      jmp_valid = jv; jmp_target = jt; cur_ip = ip; vec_rd_data = vec;
      @(negedge clk);
      // R3: clear cycle
      chk({tag, " R3 clear"}, busy && dstk_clear && !dstk_push, dstk_clear, 1);
      if (hold) begin ext_req = ~r; cur_ip = ~ip; jmp_valid = 1; jmp_target = '0; end
      else idle_inputs();
      @(negedge clk);
      chk({tag, " R3 push ip"}, dstk_push && dstk_push_data == DW'(ip), dstk_push_data, ip);
      @(negedge clk);
      // R2 R10 R6 R7: code on top
      chk({tag, " R2 R10 code"}, dstk_push && dstk_push_data == DW'(exp), dstk_push_data, exp);
      @(negedge clk);
      chk({tag, " R3 load"}, ip_load && vec_rd_en && ip_load_val == vec && vec_rd_addr == AW'(VEC0),
          ip_load_val, vec);
      idle_inputs();
      @(negedge clk);
      // R4 R5
      chk({tag, " R4 R5 idle after"}, !busy && !dstk_clear && !dstk_push, busy, 0);
   endtask

   task automatic no_entry(input string tag, input logic mv, input logic mw, input logic [AW-1:0] ma,
         input logic jv, input logic [AW-1:0] jt);
      logic ewb, erz;
      mem_valid = mv; mem_write = mw; mem_addr = ma; jmp_valid = jv; jmp_target = jt;
      ewb = mv && mw && ma >= AW'(RWE) && ma < AW'(ROE);
      erz = mv && !mw && ma >= AW'(ROE) && ma < AW'(WOE);
      #1;
      chk({tag, " R8 flags"}, sfr_wr_block == ewb && sfr_rd_zero == erz, {sfr_wr_block, sfr_rd_zero}, {ewb, erz});
      @(negedge clk);
      chk({tag, " R9 no entry"}, !busy, busy, 0);
      idle_inputs();
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1
      chk("R1 reset", !busy && !dstk_clear && !dstk_push && !vec_rd_en && !ip_load, busy, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after release", !busy, busy, 0);

      for (int i = 0; i < NC; i++)   // R10
         entry("R10 single", NC'(1) << i, 0, 0, '0, 0, '0, 16'h1234 + 16'(i), 16'h0A00 + 16'(i), 0);
      entry("R2 multi", 8'b1010_1000, 0, 0, '0, 0, '0, 16'h0300, 16'h0200, 0);
      entry("R6 undef sfr", '0, 1, 0, 16'h0030, 0, '0, 16'h0222, 16'h0400, 0);
      entry("R6 top sfr", '0, 1, 1, 16'h01FF, 0, '0, 16'h0223, 16'h0401, 0);
      entry("R7 low jump", '0, 0, 0, '0, 1, 16'h01FF, 16'h0224, 16'h0402, 0);
      entry("R2 R7 vs opcode", 8'h80, 0, 0, '0, 1, 16'h0000, 16'h0225, 16'h0403, 0);
      entry("R2 R6 vs div", 8'h02, 1, 0, 16'h0100, 0, '0, 16'h0226, 16'h0404, 0);
      entry("R5 hold", 8'h20, 0, 0, '0, 0, '0, 16'h0777, 16'h0888, 1);
      no_entry("R7 high jump", 0, 0, '0, 1, 16'h0200);
      no_entry("R8 ro write", 1, 1, 16'h0020, 0, '0);
      no_entry("R8 wo read", 1, 0, 16'h002F, 0, '0);
      no_entry("R9 rw", 1, 1, 16'h0000, 0, '0);
      no_entry("R9 high mem", 1, 0, 16'h0200, 0, '0);

      for (int n = 0; n < 60; n++) begin
         logic [NC-1:0] r;
         logic mv, jv;
         logic [AW-1:0] ma, jt;
         r  = NC'($urandom & $urandom);
         mv = 1'($urandom);
         jv = 1'($urandom);
         ma = AW'($urandom % 'h400);
         jt = AW'($urandom % 'h400);
         if (comb_req(r, mv, ma, jv, jt) != '0)
            entry("R2 random", r, mv, 1'($urandom), ma, jv, jt, AW'($urandom), AW'($urandom), 1'($urandom));
         else
            no_entry("R9 random", mv, 1'($urandom), ma, jv, jt);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule